// File: doc/BRIEF.md
# Per-Channel Stream Lockout Guard

This block watches one sub-channel of a shared-port multiplexer and measures how long that channel keeps the master port busy. A channel is treated as holding the port while its request lead is high or while its data line keeps changing. The hold time is counted in port clock enables. When the count reaches a limit picked by a 3-bit code, the channel is locked out. The lockout isolates a terminal that will not stop transmitting, and the block shows this on a stream indicator output.

Release is strict. A lockout clears only after the request lead has gone low. If the data line was active when the lockout began, the data line must also have been quiet for a set number of port clocks. The channel's out-of-service switch keeps the channel from taking the port, but it does not release a lockout that is already active. A separate enable turns the whole guard off.

Top module: `stream_guard`

## Requirements
- R1: `lockout` rises at the clock edge that carries the limit-th port clock enable counted while the channel holds the port. The count starts at zero.
- R2: `limit_code` value k selects the limit base·M, where M is 1, 2, 4, 16, 64, 256, 1024 and 2048 for k = 0 to 7, and base = 2^BASE_LOG2. The default base is 1024.
- R3: While `guard_en` is low, `lockout` is low. Dropping `guard_en` clears an active lockout at the next edge.
- R4: The channel holds the port while it is not disabled, not locked out, and either `rts` is high or a change of `data_in` was seen at one of the last QUIET_CLKS port clock enables (the current one included). The hold count advances only on `port_ce`. It restarts from zero whenever the channel stops holding before the limit is reached.
- R5: A lockout that began with the data line inactive stays set while `rts` is high. It clears at the first edge with `rts` low.
- R6: A lockout that began with the data line active clears only at an edge where `rts` is low and no change of `data_in` has been seen for QUIET_CLKS (default 16) port clock enables.
- R7: While `chan_disable` is high, the channel does not hold the port, so no count builds up. Raising `chan_disable` does not clear an active lockout.
- R8: `stream_ind` is high exactly when `lockout` is high.
- R9: After reset, `lockout` and `stream_ind` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_ce | input | 1 | Port clock enable, one pulse per port bit time |
| rts | input | 1 | Channel request lead |
| data_in | input | 1 | Channel data line |
| limit_code | input | 3 | Maximum hold-time selector |
| guard_en | input | 1 | Anti-streaming enable |
| chan_disable | input | 1 | Channel out-of-service switch |
| lockout | output | 1 | Channel locked out of the master port |
| stream_ind | output | 1 | Stream indicator |

## Verification
The hardest case to reach is a lockout caused by data. It needs the data line to toggle on every port clock for a full limit with the request lead low, and then a silence of exactly QUIET_CLKS enables before release. The bench builds the model with a small base so that every limit code can be swept to its exact edge. It then toggles the data line through a lockout, stops the toggling, and checks that the flag is still set one enable before the quiet window ends and clear one edge after it. A variant raises the request lead during the silence to show that both conditions are needed.

// File: rtl/stream_guard_pkg.sv
package stream_guard_pkg;

    // Extra left shift applied to the base limit for each limit code.
    function automatic int unsigned limit_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 1;
            3'd2:    return 2;
            3'd3:    return 4;
            3'd4:    return 6;
            3'd5:    return 8;
            3'd6:    return 10;
            default: return 11;
        endcase
    endfunction

    typedef struct packed {
        logic lockout;
        logic cause_data;
    } guard_flags_t;

endpackage

// File: rtl/sg_limit_decode.sv
module sg_limit_decode #(
    parameter int BASE_LOG2 = 10,
    parameter int CW        = BASE_LOG2 + 12
) (
    input  logic [2:0]    code,
    output logic [CW-1:0] limit
);
    import stream_guard_pkg::*;

    localparam logic [CW-1:0] ONE = CW'(1);

    always_comb begin
        limit = ONE << (BASE_LOG2 + int'(limit_shift(code)));
    end

endmodule

// File: rtl/sg_activity.sv
module sg_activity #(
    parameter int QUIET_CLKS = 16,
    parameter int QW         = $clog2(QUIET_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic port_ce,
    input  logic data_in,
    output logic active
);
    localparam logic [QW-1:0] QMAX = QW'(QUIET_CLKS);

    typedef struct packed {
        logic          prev;
        logic [QW-1:0] quiet;
    } act_state_t;

    act_state_t cur_q, nxt_d;
    logic       edge_now;

    always_comb begin
        nxt_d    = cur_q;
        edge_now = port_ce && (data_in != cur_q.prev);
        if (port_ce) begin
            nxt_d.prev = data_in;
            if (edge_now)
                nxt_d.quiet = '0;
            else if (cur_q.quiet != QMAX)
                nxt_d.quiet = cur_q.quiet + QW'(1);
        end
        active = edge_now || (cur_q.quiet != QMAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.prev  <= 1'b0;
            cur_q.quiet <= QMAX;
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.quiet <= QMAX); // R6
    AST_QUIET_ON_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !port_ce |=> $stable(cur_q.quiet)); // R6

endmodule

// File: rtl/stream_guard.sv
module stream_guard #(
    parameter int BASE_LOG2  = 10,
    parameter int QUIET_CLKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_ce,
    input  logic       rts,
    input  logic       data_in,
    input  logic [2:0] limit_code,
    input  logic       guard_en,
    input  logic       chan_disable,
    output logic       lockout,
    output logic       stream_ind
);
    import stream_guard_pkg::*;

    localparam int CW = BASE_LOG2 + 12;

    typedef struct packed {
        logic [CW-1:0] count;
        guard_flags_t  flags;
    } guard_state_t;

    guard_state_t  cur_q, nxt_d;
    logic [CW-1:0] limit;
    logic          data_active;
    logic          holding;
    logic          release_ok;

    sg_limit_decode #(.BASE_LOG2(BASE_LOG2), .CW(CW)) u_limit (
        .code  (limit_code),
        .limit (limit)
    );

    sg_activity #(.QUIET_CLKS(QUIET_CLKS)) u_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_ce (port_ce),
        .data_in (data_in),
        .active  (data_active)
    );

    always_comb begin
        nxt_d      = cur_q;
        holding    = guard_en && !chan_disable && !cur_q.flags.lockout
                     && (rts || data_active);
        release_ok = !rts && (!cur_q.flags.cause_data || !data_active);
        if (!guard_en) begin
            nxt_d.count      = '0;
            nxt_d.flags      = '0;
        end else if (cur_q.flags.lockout) begin
            nxt_d.count = '0;
            if (release_ok) begin
                nxt_d.flags = '0;
            end
        end else if (holding) begin
            if (port_ce) begin
                if (cur_q.count == limit - CW'(1)) begin
                    nxt_d.count            = '0;
                    nxt_d.flags.lockout    = 1'b1;
                    nxt_d.flags.cause_data = data_active;
                end else begin
                    nxt_d.count = cur_q.count + CW'(1);
                end
            end
        end else begin
            nxt_d.count = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign lockout    = cur_q.flags.lockout;
    assign stream_ind = cur_q.flags.lockout;

    AST_OFF_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !guard_en |=> !lockout); // R3
    AST_LOCK_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lockout) |-> $past(cur_q.count) == $past(limit) - CW'(1)); // R1
    AST_COUNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.count < limit || $changed(limit_code)); // R2
    AST_RTS_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        lockout && rts && guard_en |=> lockout); // R5
    AST_DATA_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        lockout && cur_q.flags.cause_data && data_active && guard_en |=> lockout); // R6
    AST_DISABLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        chan_disable && !lockout |=> cur_q.count == '0); // R7
    AST_IND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        stream_ind == lockout); // R8

endmodule

// File: tb/stream_guard_tb.sv
`timescale 1ns/1ps
module stream_guard_tb;
    localparam int BASE_LOG2  = 2;
    localparam int QUIET_CLKS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_ce = 1'b1;
    logic       rts = 1'b0;
    logic       data_in = 1'b0;
    logic [2:0] limit_code = 3'd0;
    logic       guard_en = 1'b1;
    logic       chan_disable = 1'b0;
    logic       lockout;
    logic       stream_ind;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    stream_guard #(.BASE_LOG2(BASE_LOG2), .QUIET_CLKS(QUIET_CLKS)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_ce      (port_ce),
        .rts          (rts),
        .data_in      (data_in),
        .limit_code   (limit_code),
        .guard_en     (guard_en),
        .chan_disable (chan_disable),
        .lockout      (lockout),
        .stream_ind   (stream_ind)
    );

    function automatic int exp_limit(input int code);
        int m;
        case (code)
            0: m = 1;    1: m = 2;    2: m = 4;     3: m = 16;
            4: m = 64;   5: m = 256;  6: m = 1024;  default: m = 2048;
        endcase
        return (1 << BASE_LOG2) * m;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic toggle_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            data_in = ~data_in;
            tick(1);
        end
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(2);
        chk("R9 lockout after reset", lockout, 1'b0);
        chk("R9 stream_ind after reset", stream_ind, 1'b0);
        rst_n = 1'b1;
        tick(2);

        // R1 R2 R5 R8: sweep all limit codes
        for (int c = 0; c < 8; c++) begin
            limit_code = 3'(c);
            rts = 1'b1;
            tick(exp_limit(c) - 1);
            chk($sformatf("R2 code %0d one short", c), lockout, 1'b0);
            tick(1);
            chk($sformatf("R1 code %0d at limit", c), lockout, 1'b1);
            chk($sformatf("R8 code %0d indicator", c), stream_ind, 1'b1);
            tick(5);
            chk($sformatf("R5 code %0d held by rts", c), lockout, 1'b1);
            rts = 1'b0;
            tick(1);
            chk($sformatf("R5 code %0d released", c), lockout, 1'b0);
            chk($sformatf("R8 code %0d indicator off", c), stream_ind, 1'b0);
            tick(2);
        end

        limit_code = 3'd0; // limit 4
        // R4: a short release restarts the count
        rts = 1'b1; tick(3);
        rts = 1'b0; tick(1);
        rts = 1'b1; tick(3);
        chk("R4 count restarted", lockout, 1'b0);
        tick(1);
        chk("R4 full limit after restart", lockout, 1'b1);
        rts = 1'b0; tick(2);

        // R4: count frozen without port_ce
        port_ce = 1'b0; rts = 1'b1; tick(50);
        chk("R4 no count without port_ce", lockout, 1'b0);
        port_ce = 1'b1; tick(3);
        chk("R4 count from zero after ce", lockout, 1'b0);
        tick(1);
        chk("R4 lock after ce resumes", lockout, 1'b1);
        rts = 1'b0; tick(2);

        // R7: disabled channel never counts; disable does not clear lockout
        chan_disable = 1'b1; rts = 1'b1; tick(40);
        chk("R7 disabled does not lock", lockout, 1'b0);
        chan_disable = 1'b0; tick(3);
        chk("R7 count starts at enable", lockout, 1'b0);
        tick(1);
        chk("R7 lock after enable", lockout, 1'b1);
        chan_disable = 1'b1; tick(10);
        chk("R7 disable keeps lockout", lockout, 1'b1);
        rts = 1'b0; tick(1);
        chk("R7 released by rts while disabled", lockout, 1'b0);
        chan_disable = 1'b0; tick(2);

        // R3: guard off
        guard_en = 1'b0; rts = 1'b1; tick(30);
        chk("R3 guard off no lock", lockout, 1'b0);
        guard_en = 1'b1; tick(4);
        chk("R3 lock with guard on", lockout, 1'b1);
        guard_en = 1'b0; tick(1);
        chk("R3 guard off clears", lockout, 1'b0);
        rts = 1'b0; guard_en = 1'b1; tick(2);

        // R6: data-caused lockout, request lead low
        toggle_ticks(3);
        chk("R6 data one short", lockout, 1'b0);
        toggle_ticks(1);
        chk("R6 data lock at limit", lockout, 1'b1);
        toggle_ticks(5);
        chk("R6 held while toggling", lockout, 1'b1);
        tick(QUIET_CLKS);
        chk("R6 held through quiet window", lockout, 1'b1);
        tick(1);
        chk("R6 released after quiet", lockout, 1'b0);
        tick(2);

        // R6: quiet data but rts high keeps data-caused lockout
        toggle_ticks(4);
        chk("R6 second data lock", lockout, 1'b1);
        rts = 1'b1;
        tick(QUIET_CLKS + 10);
        chk("R6 rts high blocks release", lockout, 1'b1);
        rts = 1'b0; tick(1);
        chk("R6 release when both stop", lockout, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule